// File: doc/BRIEF.md
# Inter-Processor Command Decoder with Secondary-CPU Boot Sequencing

This block turns a 64-bit inter-processor command word into per-CPU delivery requests for a cluster of `NUM_CPU` processors. The command reaches the block through two register halves. In the narrow-ID mode the upper half is staged first and a write to the lower half launches the command. In the wide-ID mode a single lower-half write carries the whole word. Fixed-vector and non-maskable commands fan out to the CPUs picked by a two-bit shorthand. The requests appear as one-cycle masks on the cycle after the launching write.

The block also tracks the boot state of every secondary CPU. CPU 0 comes out of reset running. Each other CPU sits in a held state until CPU 0 sends it an asserting INIT, which arms it. A later STARTUP command moves an armed CPU to running. That STARTUP also emits a one-cycle start pulse naming the CPU and a start address formed from the command vector. The running mask doubles as the set of active CPUs that the broadcast shorthands address. Commands the block cannot complete on its own raise a one-cycle `unhandled` flag so that a higher layer can take them over.

The write strobes are plain control inputs. Every command is accepted in the cycle it is presented, and there is no back-pressure. Injection into a core and the start of execution happen outside this block.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset CPU 0 reads as running, every other CPU is in the held (not armed, not running) state, and all request, pulse and flag outputs are zero.
- R2: Command field layout: vector in bits 7:0; delivery mode in bits 10:8 (000 fixed, 100 non-maskable, 101 INIT, 110 STARTUP); level in bit 14; shorthand in bits 19:18. A launching write takes effect on the outputs at the next clock edge, and those outputs last one cycle.
- R3: In narrow-ID mode (`wide_id`=0), a high-half write stores `wr_data[31:0]` and changes no output. A low-half write joins `wr_data[31:0]` with the stored high half and executes the result, with the destination taken from bits 63:56 of that word.
- R4: In wide-ID mode, a low-half write executes `wr_data[63:0]` with the destination in bits 63:32. A high-half write leaves the stored high half unchanged.
- R5: Shorthand 00 selects the CPU whose index equals the destination, or no CPU if the destination is not below `NUM_CPU`. 01 selects the sender (`src_cpu`), 10 selects all running CPUs, and 11 selects all running CPUs except the sender.
- R6: A fixed command sets `fix_req` to the selected mask and `fix_vec` to the vector.
- R7: A non-maskable command sets `nmi_req` to the selected mask and leaves `fix_req` zero.
- R8: An INIT with level 0 changes no boot state and raises no flag.
- R9: An INIT with level 1 from CPU 0 to a destination from 1 to `NUM_CPU`-1 arms a held target. A target in any other state is left unchanged.
- R10: A STARTUP from CPU 0 to a destination from 1 to `NUM_CPU`-1 starts only an armed target. That target becomes running and `start_pulse` rises with `start_cpu` equal to the destination and `start_addr` equal to the vector shifted left by 12. For a target in any other state the command is dropped silently.
- R11: `unhandled` rises for delivery modes 001, 010, 011 and 111, and for an INIT with level 1 or a STARTUP whose sender is not CPU 0 or whose destination is 0 or not below `NUM_CPU`. It never rises together with a request or start pulse.
- R12: A running CPU stays running until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_id | input | 1 | 1 selects wide-ID mode, 0 narrow-ID mode |
| src_cpu | input | CPU_W | Index of the CPU issuing the command |
| wr_lo | input | 1 | Low-half write strobe (launches the command) |
| wr_hi | input | 1 | High-half write strobe |
| wr_data | input | 64 | Write data |
| fix_req | output | NUM_CPU | Fixed-vector request mask, one cycle |
| fix_vec | output | 8 | Vector accompanying `fix_req` |
| nmi_req | output | NUM_CPU | Non-maskable request mask, one cycle |
| start_pulse | output | 1 | A secondary CPU has been started |
| start_cpu | output | CPU_W | CPU started by `start_pulse` |
| start_addr | output | 20 | Start address for that CPU |
| unhandled | output | 1 | Command needs handling elsewhere |
| running | output | NUM_CPU | Running (active) CPU mask |

## Verification
The bound checker watches, on every cycle, that CPU 0 stays running and that no running bit ever drops. It also checks that a start pulse only names a secondary CPU that has just become running, that no request or flag appears without a launching low-half write, and that the fixed and non-maskable masks and the unhandled flag never coincide. Only the bench's scenarios can show that the masks match each shorthand and destination for the current running set, that the staged high half is joined correctly in each mode, and that out-of-order INIT and STARTUP commands leave the boot states untouched.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [1:0] {
    BOOT_HELD  = 2'd0,
    BOOT_ARMED = 2'd1,
    BOOT_RUN   = 2'd2
  } boot_e;

  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [2:0] DM_FIXED = 3'b000;
  localparam logic [2:0] DM_NMI   = 3'b100;
  localparam logic [2:0] DM_INIT  = 3'b101;
  localparam logic [2:0] DM_START = 3'b110;

  localparam int VEC_W      = 8;
  localparam int ADDR_SHIFT = 12;
  localparam int ADDR_W     = VEC_W + ADDR_SHIFT;

  typedef struct packed {
    logic [31:0]      dest;
    shorthand_e       sh;
    logic             level;
    logic [2:0]       mode;
    logic [VEC_W-1:0] vec;
  } cmd_t;

endpackage

// File: rtl/ipi_cmd_capture.sv
module ipi_cmd_capture
  import ipi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wide_id,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [63:0] wr_data,
  output logic        cmd_go,
  output cmd_t        cmd
);

  logic [31:0] hi_q;
  logic [63:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (wr_hi && !wide_id) begin
      hi_q <= wr_data[31:0];
    end
  end

  always_comb begin
    word      = wide_id ? wr_data : {hi_q, wr_data[31:0]};
    cmd.vec   = word[7:0];
    cmd.mode  = word[10:8];
    cmd.level = word[14];
    cmd.sh    = shorthand_e'(word[19:18]);
    cmd.dest  = wide_id ? word[63:32] : {24'd0, word[63:56]};
  end

  assign cmd_go = wr_lo;

endmodule

// File: rtl/ipi_target_fanout.sv
module ipi_target_fanout
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  cmd_t               cmd,
  input  logic [CPU_W-1:0]   src_cpu,
  input  logic [NUM_CPU-1:0] running,
  output logic [NUM_CPU-1:0] tgt_mask,
  output logic               dest_ok,
  output logic [CPU_W-1:0]   dest_idx
);

  logic [NUM_CPU-1:0] dest_hit;
  logic [NUM_CPU-1:0] self_hit;

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_sel
    assign dest_hit[i] = (cmd.dest == 32'(i));
    assign self_hit[i] = (src_cpu == CPU_W'(i));
  end

  always_comb begin
    unique case (cmd.sh)
      SH_DEST:   tgt_mask = dest_hit;
      SH_SELF:   tgt_mask = self_hit;
      SH_ALL:    tgt_mask = running;
      SH_OTHERS: tgt_mask = running & ~self_hit;
      default:   tgt_mask = '0;
    endcase
  end

  assign dest_ok  = (cmd.dest != 32'd0) && (cmd.dest < 32'(NUM_CPU));
  assign dest_idx = cmd.dest[CPU_W-1:0];

endmodule

// File: rtl/ipi_boot_seq.sv
module ipi_boot_seq
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_go,
  input  logic               start_go,
  input  logic [CPU_W-1:0]   dest_idx,
  output logic [NUM_CPU-1:0] running,
  output logic [NUM_CPU-1:0] armed
);

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
    if (i == 0) begin : g_primary
      assign running[i] = 1'b1;
      assign armed[i]   = 1'b0;
    end else begin : g_secondary
      boot_e st_q;
      logic  sel;

      assign sel = (dest_idx == CPU_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q <= BOOT_HELD;
        end else if (sel) begin
          if (init_go && st_q == BOOT_HELD) begin
            st_q <= BOOT_ARMED;
          end else if (start_go && st_q == BOOT_ARMED) begin
            st_q <= BOOT_RUN;
          end
        end
      end

      assign running[i] = (st_q == BOOT_RUN);
      assign armed[i]   = (st_q == BOOT_ARMED);
    end
  end

endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wide_id,
  input  logic [CPU_W-1:0]   src_cpu,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [63:0]        wr_data,
  output logic [NUM_CPU-1:0] fix_req,
  output logic [7:0]         fix_vec,
  output logic [NUM_CPU-1:0] nmi_req,
  output logic               start_pulse,
  output logic [CPU_W-1:0]   start_cpu,
  output logic [ADDR_W-1:0]  start_addr,
  output logic               unhandled,
  output logic [NUM_CPU-1:0] running
);

  cmd_t               cmd;
  logic               cmd_go;
  logic [NUM_CPU-1:0] tgt_mask;
  logic               dest_ok;
  logic [CPU_W-1:0]   dest_idx;
  logic [NUM_CPU-1:0] armed;

  ipi_cmd_capture u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .wide_id (wide_id),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wr_data (wr_data),
    .cmd_go  (cmd_go),
    .cmd     (cmd)
  );

  ipi_target_fanout #(.NUM_CPU(NUM_CPU)) u_fanout (
    .cmd      (cmd),
    .src_cpu  (src_cpu),
    .running  (running),
    .tgt_mask (tgt_mask),
    .dest_ok  (dest_ok),
    .dest_idx (dest_idx)
  );

  logic is_fix, is_nmi, is_init, is_start, from_primary;
  logic init_quiet, init_ok, start_ok, start_fire, kicked_out;

  always_comb begin
    is_fix       = (cmd.mode == DM_FIXED);
    is_nmi       = (cmd.mode == DM_NMI);
    is_init      = (cmd.mode == DM_INIT);
    is_start     = (cmd.mode == DM_START);
    from_primary = (src_cpu == '0);
    init_quiet   = is_init && !cmd.level;
    init_ok      = is_init && cmd.level && from_primary && dest_ok;
    start_ok     = is_start && from_primary && dest_ok;
    start_fire   = start_ok && armed[dest_idx];
    kicked_out   = !(is_fix || is_nmi || init_quiet || init_ok || start_ok);
  end

  ipi_boot_seq #(.NUM_CPU(NUM_CPU)) u_boot (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_go  (cmd_go && init_ok),
    .start_go (cmd_go && start_ok),
    .dest_idx (dest_idx),
    .running  (running),
    .armed    (armed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_req     <= '0;
      fix_vec     <= '0;
      nmi_req     <= '0;
      start_pulse <= 1'b0;
      start_cpu   <= '0;
      start_addr  <= '0;
      unhandled   <= 1'b0;
    end else begin
      fix_req     <= (cmd_go && is_fix) ? tgt_mask : '0;
      fix_vec     <= (cmd_go && is_fix) ? cmd.vec : '0;
      nmi_req     <= (cmd_go && is_nmi) ? tgt_mask : '0;
      start_pulse <= cmd_go && start_fire;
      start_cpu   <= (cmd_go && start_fire) ? dest_idx : '0;
      start_addr  <= (cmd_go && start_fire) ? {cmd.vec, {ADDR_SHIFT{1'b0}}} : '0;
      unhandled   <= cmd_go && kicked_out;
    end
  end

endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk #(
  parameter int NUM_CPU = 4,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_lo,
  input logic [NUM_CPU-1:0] fix_req,
  input logic [NUM_CPU-1:0] nmi_req,
  input logic               start_pulse,
  input logic [CPU_W-1:0]   start_cpu,
  input logic               unhandled,
  input logic [NUM_CPU-1:0] running
);

  p_primary_runs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    running[0]);

  p_run_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((running & $past(running)) == $past(running)));

  p_start_fresh_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (start_cpu != '0) && running[start_cpu]
                    && ((($past(running) >> start_cpu) & 1) == 0));

  p_needs_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|fix_req) || (|nmi_req) || start_pulse || unhandled) |-> $past(wr_lo));

  p_kinds_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !((|fix_req) && (|nmi_req)));

  p_unhandled_alone_r11: assert property (@(posedge clk) disable iff (!rst_n)
    unhandled |-> (fix_req == '0) && (nmi_req == '0) && !start_pulse);

endmodule

bind ipi_dispatch ipi_dispatch_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_lo       (wr_lo),
  .fix_req     (fix_req),
  .nmi_req     (nmi_req),
  .start_pulse (start_pulse),
  .start_cpu   (start_cpu),
  .unhandled   (unhandled),
  .running     (running)
);

// File: tb/ipi_dispatch_test.sv
`timescale 1ns/1ps
module ipi_dispatch_test;

  localparam int N  = 4;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wide_id = 1'b0;
  logic [CW-1:0] src_cpu = '0;
  logic          wr_lo = 1'b0;
  logic          wr_hi = 1'b0;
  logic [63:0]   wr_data = '0;
  logic [N-1:0]  fix_req, nmi_req, running;
  logic [7:0]    fix_vec;
  logic          start_pulse, unhandled;
  logic [CW-1:0] start_cpu;
  logic [19:0]   start_addr;

  always #2.5 clk = ~clk;

  ipi_dispatch #(.NUM_CPU(N)) uut (
    .clk(clk), .rst_n(rst_n), .wide_id(wide_id), .src_cpu(src_cpu),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .fix_req(fix_req), .fix_vec(fix_vec), .nmi_req(nmi_req),
    .start_pulse(start_pulse), .start_cpu(start_cpu), .start_addr(start_addr),
    .unhandled(unhandled), .running(running)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [N-1:0] model_run = 4'b0001;

  task automatic check(string req, string what, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [7:0] vec, logic [2:0] mode, logic lvl, logic [1:0] sh);
    return 32'(vec) | (32'(mode) << 8) | (32'(lvl) << 14) | (32'(sh) << 18);
  endfunction

  function automatic logic [N-1:0] exp_mask(logic [1:0] sh, int src, logic [31:0] dest, logic [N-1:0] run);
    case (sh)
      2'd0:    return (dest < N) ? N'(1 << dest) : '0;
      2'd1:    return N'(1 << src);
      2'd2:    return run;
      default: return run & ~N'(1 << src);
    endcase
  endfunction

  task automatic expect_out(string req, logic [N-1:0] fx, logic [7:0] fv, logic [N-1:0] nm,
                            logic sp, logic [CW-1:0] sc, logic [19:0] sa, logic un);
    check(req, "fix_req", 64'(fix_req), 64'(fx));
    if (fx != '0) check(req, "fix_vec", 64'(fix_vec), 64'(fv));
    check(req, "nmi_req", 64'(nmi_req), 64'(nm));
    check(req, "start_pulse", 64'(start_pulse), 64'(sp));
    if (sp) begin
      check(req, "start_cpu", 64'(start_cpu), 64'(sc));
      check(req, "start_addr", 64'(start_addr), 64'(sa));
    end
    check(req, "unhandled", 64'(unhandled), 64'(un));
    check(req, "running", 64'(running), 64'(model_run));
  endtask

  task automatic send_wide(logic [31:0] dest, logic [31:0] low);
    @(negedge clk);
    wide_id = 1'b1; wr_data = {dest, low}; wr_lo = 1'b1;
    @(negedge clk);
    wr_lo = 1'b0;
  endtask

  task automatic send_narrow(logic [7:0] dest, logic [31:0] low);
    @(negedge clk);
    wide_id = 1'b0; wr_data = {32'hA5A5_5A5A, dest, 24'h00_1234}; wr_hi = 1'b1;
    @(negedge clk);
    wr_hi = 1'b0;
    check("R3", "hi write quiet", 64'({fix_req, nmi_req, start_pulse, unhandled}), 64'd0);
    wr_data = {8'h03, 24'h0, low}; wr_lo = 1'b1;
    @(negedge clk);
    wr_lo = 1'b0;
  endtask

  task automatic sweep(bit narrow);
    for (int s = 0; s < N; s++) begin
      for (int sh = 0; sh < 4; sh++) begin
        for (int j = 0; j < 6; j++) begin
          for (int m = 0; m < 2; m++) begin
            logic [31:0] d;
            logic [7:0]  v;
            logic [N-1:0] msk;
            d = (j < 5) ? 32'(j) : (narrow ? 32'd255 : 32'h0000_0100);
            v = 8'((s * 37 + j * 11 + sh * 3 + m * 101 + 32) & 255);
            src_cpu = CW'(s);
            if (narrow) send_narrow(d[7:0], mk(v, m ? 3'b100 : 3'b000, 1'b1, 2'(sh)));
            else        send_wide(d, mk(v, m ? 3'b100 : 3'b000, 1'b1, 2'(sh)));
            msk = exp_mask(2'(sh), s, d, model_run);
            if (m == 0) expect_out("R5 R6", msk, v, '0, 1'b0, '0, '0, 1'b0);
            else        expect_out("R5 R7", '0, 8'd0, msk, 1'b0, '0, '0, 1'b0);
          end
        end
      end
    end
    src_cpu = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_out("R1", '0, 8'd0, '0, 1'b0, '0, '0, 1'b0);

    // R5 R6 R7 with only CPU 0 running, both modes (R3, R4)
    sweep(1'b0);
    sweep(1'b1);

    // R11 unsupported delivery modes
    for (int md = 1; md < 8; md++) begin
      if (md == 4 || md == 5 || md == 6) continue;
      send_wide(32'd1, mk(8'h44, 3'(md), 1'b1, 2'd0));
      expect_out("R11", '0, 8'd0, '0, 1'b0, '0, '0, 1'b1);
    end

    // R10 STARTUP to a held CPU is dropped
    send_narrow(8'd1, mk(8'h9A, 3'b110, 1'b0, 2'd0));
    expect_out("R10", '0, 8'd0, '0, 1'b0, '0, '0, 1'b0);
    // R8 deasserted INIT ignored, target still not armed
    send_narrow(8'd1, mk(8'h00, 3'b101, 1'b0, 2'd0));
    expect_out("R8", '0, 8'd0, '0, 1'b0, '0, '0, 1'b0);
    send_narrow(8'd1, mk(8'h9A, 3'b110, 1'b0, 2'd0));
    expect_out("R8", '0, 8'd0, '0, 1'b0, '0, '0, 1'b0);
    // R11 bad sender / destination for INIT and STARTUP
    src_cpu = 2'd1;
    send_narrow(8'd2, mk(8'h00, 3'b101, 1'b1, 2'd0));
    expect_out("R11", '0, 8'd0, '0, 1'b0, '0, '0, 1'b1);
    send_narrow(8'd2, mk(8'h10, 3'b110, 1'b1, 2'd0));
    expect_out("R11", '0, 8'd0, '0, 1'b0, '0, '0, 1'b1);
    src_cpu = 2'd0;
    send_narrow(8'd0, mk(8'h00, 3'b101, 1'b1, 2'd0));
    expect_out("R11", '0, 8'd0, '0, 1'b0, '0, '0, 1'b1);
    send_narrow(8'd4, mk(8'h00, 3'b101, 1'b1, 2'd0));
    expect_out("R11", '0, 8'd0, '0, 1'b0, '0, '0, 1'b1);
    send_wide(32'h0000_0102, mk(8'h10, 3'b110, 1'b1, 2'd0));
    expect_out("R11", '0, 8'd0, '0, 1'b0, '0, '0, 1'b1);
    // CPU 2 must still be held after the rejected commands
    send_narrow(8'd2, mk(8'h10, 3'b110, 1'b0, 2'd0));
    expect_out("R11", '0, 8'd0, '0, 1'b0, '0, '0, 1'b0);

    // R9 arm CPU 1, R10 start it
    send_narrow(8'd1, mk(8'h00, 3'b101, 1'b1, 2'd0));
    expect_out("R9", '0, 8'd0, '0, 1'b0, '0, '0, 1'b0);
    send_narrow(8'd1, mk(8'h9A, 3'b110, 1'b0, 2'd0));
    model_run = 4'b0011;
    expect_out("R10", '0, 8'd0, '0, 1'b1, 2'd1, 20'h9A000, 1'b0);
    send_narrow(8'd1, mk(8'h55, 3'b110, 1'b0, 2'd0));
    expect_out("R10", '0, 8'd0, '0, 1'b0, '0, '0, 1'b0);
    // R9 INIT to running CPU 1 leaves it running; R12
    send_narrow(8'd1, mk(8'h00, 3'b101, 1'b1, 2'd0));
    expect_out("R12", '0, 8'd0, '0, 1'b0, '0, '0, 1'b0);
    send_narrow(8'd1, mk(8'h55, 3'b110, 1'b0, 2'd0));
    expect_out("R9", '0, 8'd0, '0, 1'b0, '0, '0, 1'b0);

    // R9 R10 in wide mode, out-of-order starts
    send_wide(32'd2, mk(8'h00, 3'b101, 1'b1, 2'd0));
    send_wide(32'd3, mk(8'h00, 3'b101, 1'b1, 2'd0));
    expect_out("R9", '0, 8'd0, '0, 1'b0, '0, '0, 1'b0);
    send_wide(32'd3, mk(8'hFF, 3'b110, 1'b0, 2'd0));
    model_run = 4'b1011;
    expect_out("R10", '0, 8'd0, '0, 1'b1, 2'd3, 20'hFF000, 1'b0);
    send_wide(32'd2, mk(8'h01, 3'b110, 1'b0, 2'd0));
    model_run = 4'b1111;
    expect_out("R10", '0, 8'd0, '0, 1'b1, 2'd2, 20'h01000, 1'b0);

    // R4 high write in wide mode does not replace the staged half
    @(negedge clk);
    wide_id = 1'b0; wr_hi = 1'b1; wr_data = {32'h0, 8'd2, 24'h0};
    @(negedge clk);
    wide_id = 1'b1; wr_data = {32'h0, 8'd3, 24'h0};
    @(negedge clk);
    wr_hi = 1'b0; wide_id = 1'b0; wr_lo = 1'b1; wr_data = {32'h0, mk(8'h77, 3'b000, 1'b0, 2'd0)};
    @(negedge clk);
    wr_lo = 1'b0;
    expect_out("R4", 4'b0100, 8'h77, '0, 1'b0, '0, '0, 1'b0);

    // R5 R6 R7 with all CPUs running
    sweep(1'b1);
    sweep(1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule